// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is kept or dropped, judging only by the frame's 48-bit destination address. The receive path announces a new frame with a start pulse that carries the frame length, then streams the destination bytes one per valid cycle, first byte on the wire first. Six bytes after the start, the filter raises a one-cycle decision strobe. The accept flag beside the strobe stays put until the next frame begins.

A frame is kept when any of these holds:
- it matches one of two programmable station addresses that is switched on;
- broadcast acceptance is on and the address is all ones;
- it hits a 64-bit group hash table.

The hash index is six bits wide. It is the XOR of the eight 6-bit slices of the address, with the address taken in wire bit order. By default only group (multicast) addresses may use the hash table. A control bit extends hashing to individual addresses. Frames shorter than the minimum length are always rejected.

A simple word-write port loads the settings. The filter copies all settings when a frame starts, so a write never disturbs a frame that is already being judged.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, `decValid` and `decAccept` are 0, and all settings words read as zero, so every switch is off.
- R2: Register index 0 is the low word and index 1 the high word of station address A. Control bit 0 (register index 6) enables it. Wire bytes 0 to 3 are compared with low-word bits 7:0, 15:8, 23:16 and 31:24, and bytes 4 and 5 with high-word bits 7:0 and 15:8. A full match with the enable set accepts the frame.
- R3: Indices 2 and 3 hold station address B, with the same byte layout. Control bit 1 enables it.
- R4: When control bit 3 is set, an all-ones destination is accepted.
- R5: Let the 48-bit value be wire byte 0 in bits 7:0 up to byte 5 in bits 47:40. The hash index is the XOR of its eight 6-bit slices. Index 0 to 31 selects that bit of register index 4, and index 32 to 63 selects bit (index-32) of register index 5. A selected bit of 1 accepts the frame.
- R6: A destination whose wire byte 0 bit 0 is 0 (individual) never hits the hash table unless control bit 2 is set.
- R7: A frame whose `frmLen` is below 12 is rejected whatever its address.
- R8: Suppose the sixth byte after `frmStart` is sampled at clock edge k. Then `decValid` is 1 for exactly the cycle that follows edge k+1, and `decAccept` carries the decision from that edge. `decAccept` then holds until the edge that samples the next `frmStart`, which clears it to 0. Further bytes, and bytes sent in the `frmStart` cycle, are ignored.
- R9: Each frame uses the settings in force before the edge that samples its `frmStart`. A write sampled at that same edge, or later, applies from the next frame onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Settings write strobe |
| regWrIdx | input | 3 | Settings word index (0..6) |
| regWrData | input | 32 | Settings write data |
| frmStart | input | 1 | New frame pulse; `frmLen` valid with it |
| frmLen | input | LEN_W | Frame length in bytes |
| byteValid | input | 1 | Destination byte valid |
| byteData | input | 8 | Destination byte, wire order |
| decValid | output | 1 | One-cycle decision strobe |
| decAccept | output | 1 | Decision: 1 keeps the frame |

## Verification
A settings write can land in the same cycle as a frame start, or in the middle of a frame's address bytes. The bench drives both cases: it changes the control word in the very cycle `frmStart` is high, and again while the bytes are flowing. The frame under way must then be judged with the old control word, and the following frame with the new one. The cycle-by-cycle model in the bench copies its settings at the start pulse before it applies that cycle's write. Every clock is compared against it, and explicit per-frame checks confirm both decisions.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_BITS  = ADDR_BYTES * 8;
  localparam int HASH_W     = 6;
  localparam int HASH_SLICES = ADDR_BITS / HASH_W;
  localparam int HASH_SIZE  = 1 << HASH_W;
  localparam int REG_IDX_W  = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    REG_STA_LO  = 3'd0,
    REG_STA_HI  = 3'd1,
    REG_STB_LO  = 3'd2,
    REG_STB_HI  = 3'd3,
    REG_HASH_LO = 3'd4,
    REG_HASH_HI = 3'd5,
    REG_CTRL    = 3'd6
  } regIdx_e;

  typedef struct packed {
    logic bcastEn;
    logic hashUnicast;
    logic stbEn;
    logic staEn;
  } rxCtrl_t;

  typedef struct packed {
    logic cfgLatch;
    logic byteShift;
    logic evalNow;
  } ctrlStrobe_t;
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frmStart,
  input  logic        byteValid,
  output ctrlStrobe_t strobe
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);

  logic [CNT_W-1:0] byteCnt;
  logic             active;
  logic             evalPend;

  assign strobe.cfgLatch  = frmStart;
  assign strobe.byteShift = byteValid && active && !frmStart &&
                            (byteCnt < CNT_W'(ADDR_BYTES));
  assign strobe.evalNow   = evalPend && !frmStart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt  <= '0;
      active   <= 1'b0;
      evalPend <= 1'b0;
    end else begin
      evalPend <= strobe.byteShift && (byteCnt == CNT_W'(ADDR_BYTES - 1));
      if (frmStart) begin
        byteCnt <= '0;
        active  <= 1'b1;
      end else if (strobe.byteShift) begin
        byteCnt <= byteCnt + 1'b1;
      end
    end
  end

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= CNT_W'(ADDR_BYTES));

  // R8
  eval_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.evalNow |=> !strobe.evalNow);
endmodule

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int LEN_W   = 11,
  parameter int MIN_LEN = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [7:0]           byteData,
  input  logic [LEN_W-1:0]     frmLen,
  input  logic                 regWrEn,
  input  logic [REG_IDX_W-1:0] regWrIdx,
  input  logic [31:0]          regWrData,
  output logic                 decValid,
  output logic                 decAccept
);
  logic [31:0]          staLo, stbLo, hashLo, hashHi;
  logic [15:0]          staHi, stbHi;
  rxCtrl_t              ctrlReg;

  logic [ADDR_BITS-1:0] shSta, shStb;
  logic [HASH_SIZE-1:0] shHash;
  rxCtrl_t              shCtrl;
  logic                 shShort;

  logic [ADDR_BITS-1:0] addrVal;
  logic [HASH_W-1:0]    hashIdx;
  logic                 staHit, stbHit, bcastHit, hashHit, passNow;

  // settings words, written any time
  always_ff @(posedge clk) begin
    if (!rstN) begin
      staLo <= '0; staHi <= '0; stbLo <= '0; stbHi <= '0;
      hashLo <= '0; hashHi <= '0; ctrlReg <= '0;
    end else if (regWrEn) begin
      case (regWrIdx)
        REG_STA_LO:  staLo   <= regWrData;
        REG_STA_HI:  staHi   <= regWrData[15:0];
        REG_STB_LO:  stbLo   <= regWrData;
        REG_STB_HI:  stbHi   <= regWrData[15:0];
        REG_HASH_LO: hashLo  <= regWrData;
        REG_HASH_HI: hashHi  <= regWrData;
        REG_CTRL:    ctrlReg <= rxCtrl_t'(regWrData[3:0]);
        default: ;
      endcase
    end
  end

  // per-frame copy of the settings
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shSta <= '0; shStb <= '0; shHash <= '0; shCtrl <= '0; shShort <= 1'b0;
    end else if (strobe.cfgLatch) begin
      shSta   <= {staHi, staLo};
      shStb   <= {stbHi, stbLo};
      shHash  <= {hashHi, hashLo};
      shCtrl  <= ctrlReg;
      shShort <= (frmLen < LEN_W'(MIN_LEN));
    end
  end

  // destination capture: first wire byte ends in the low byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrVal <= '0;
    end else if (strobe.byteShift) begin
      addrVal <= {byteData, addrVal[ADDR_BITS-1:8]};
    end
  end

  // hash: XOR of all 6-bit slices
  always_comb begin
    hashIdx = '0;
    for (int i = 0; i < HASH_SLICES; i++) begin
      hashIdx = hashIdx ^ addrVal[i*HASH_W +: HASH_W];
    end
  end

  assign staHit   = shCtrl.staEn && (addrVal == shSta);
  assign stbHit   = shCtrl.stbEn && (addrVal == shStb);
  assign bcastHit = shCtrl.bcastEn && (&addrVal);
  assign hashHit  = shHash[hashIdx] && (addrVal[0] || shCtrl.hashUnicast);
  assign passNow  = !shShort && (staHit || stbHit || bcastHit || hashHit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid  <= 1'b0;
      decAccept <= 1'b0;
    end else begin
      decValid <= strobe.evalNow;
      if (strobe.cfgLatch) begin
        decAccept <= 1'b0;
      end else if (strobe.evalNow) begin
        decAccept <= passNow;
      end
    end
  end

  // R7
  short_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && shShort) |-> !decAccept);

  // R8
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cfgLatch |=> (!decAccept && !decValid));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.cfgLatch && !strobe.evalNow) |=> $stable(decAccept));

  // R9
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cfgLatch |=> ($stable(shCtrl) && $stable(shHash)));
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int LEN_W   = 11,
  parameter int MIN_LEN = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regWrIdx,
  input  logic [31:0]      regWrData,
  input  logic             frmStart,
  input  logic [LEN_W-1:0] frmLen,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  output logic             decValid,
  output logic             decAccept
);
  ctrlStrobe_t strobe;

  rxf_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .frmStart  (frmStart),
    .byteValid (byteValid),
    .strobe    (strobe)
  );

  rxf_datapath #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .byteData  (byteData),
    .frmLen    (frmLen),
    .regWrEn   (regWrEn),
    .regWrIdx  (regWrIdx),
    .regWrData (regWrData),
    .decValid  (decValid),
    .decAccept (decAccept)
  );
endmodule

// File: tb/rx_dest_filter_tb.sv
module rx_dest_filter_tb_top;
  localparam int LEN_W = 11;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regWrEn = 1'b0;
  logic [2:0]       regWrIdx = '0;
  logic [31:0]      regWrData = '0;
  logic             frmStart = 1'b0;
  logic [LEN_W-1:0] frmLen = '0;
  logic             byteValid = 1'b0;
  logic [7:0]       byteData = '0;
  logic             decValid, decAccept;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_dest_filter #(.LEN_W(LEN_W), .MIN_LEN(12)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrIdx(regWrIdx),
    .regWrData(regWrData), .frmStart(frmStart), .frmLen(frmLen),
    .byteValid(byteValid), .byteData(byteData),
    .decValid(decValid), .decAccept(decAccept)
  );

  // ---------------- behavioural reference model ----------------
  int unsigned mReg [7];
  int unsigned snap [7];
  logic [7:0]  q [$];
  bit mActive, mPend, mShort, expValid, expAcc;

  function automatic int hashOf(input logic [7:0] b [6]);
    int h = 0;
    for (int bit_i = 0; bit_i < 48; bit_i++)
      if (b[bit_i / 8][bit_i % 8]) h = h ^ (1 << (bit_i % 6));
    return h;
  endfunction

  function automatic logic [7:0] stationByte(input int unsigned lo, input int unsigned hi,
                                             input int k);
    if (k < 4) return 8'(lo >> (8 * k));
    return 8'(hi >> (8 * (k - 4)));
  endfunction

  function automatic bit decide();
    logic [7:0] b [6];
    bit mA = 1, mB = 1, allOnes = 1, hit;
    int h;
    if (mShort) return 0;
    for (int k = 0; k < 6; k++) begin
      b[k] = q[k];
      if (b[k] != stationByte(snap[0], snap[1], k)) mA = 0;
      if (b[k] != stationByte(snap[2], snap[3], k)) mB = 0;
      if (b[k] != 8'hFF) allOnes = 0;
    end
    h = hashOf(b);
    hit = (h < 32) ? snap[4][h] : snap[5][h - 32];
    if (!b[0][0] && !snap[6][2]) hit = 0;
    return (snap[6][0] && mA) || (snap[6][1] && mB) || (snap[6][3] && allOnes) || hit;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mReg[k]) mReg[k] = 0;
      foreach (snap[k]) snap[k] = 0;
      q.delete();
      mActive = 0; mPend = 0; mShort = 0; expValid = 0; expAcc = 0;
    end else begin
      expValid = 0;
      if (mPend) begin
        if (!frmStart) begin
          expValid = 1;
          expAcc = decide();
        end
        mPend = 0;
      end
      if (frmStart) begin
        foreach (snap[k]) snap[k] = mReg[k];
        q.delete();
        expAcc = 0;
        mActive = 1;
        mShort = (frmLen < 12);
      end else if (byteValid && mActive && q.size() < 6) begin
        q.push_back(byteData);
        if (q.size() == 6) mPend = 1;
      end
      if (regWrEn && regWrIdx < 7) mReg[regWrIdx] = regWrData;
    end
  end

  // compare against the model on every clock (R8 timing and hold)
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (decValid !== expValid || decAccept !== expAcc) begin
        failures++;
        $display("FAIL R8 cycle compare: valid=%0b accept=%0b expected valid=%0b accept=%0b",
                 decValid, decAccept, expValid, expAcc);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic wrReg(input int idx, input logic [31:0] data);
    regWrEn = 1; regWrIdx = 3'(idx); regWrData = data;
    @(negedge clk);
    regWrEn = 0;
  endtask

  // wrAt: -1 none, 0 with the start pulse, k>0 together with byte k-1
  task automatic sendFrame(input logic [47:0] addr, input int len, input string tag,
                           input logic expA, input int wrAt, input int wrIdx,
                           input logic [31:0] wrData);
    frmStart = 1; frmLen = LEN_W'(len);
    byteValid = 1; byteData = 8'hA5;          // ignored in the start cycle
    if (wrAt == 0) begin regWrEn = 1; regWrIdx = 3'(wrIdx); regWrData = wrData; end
    @(negedge clk);
    frmStart = 0; regWrEn = 0;
    for (int k = 0; k < 6; k++) begin
      byteValid = 1; byteData = addr[8*k +: 8];
      if (wrAt == k + 1) begin regWrEn = 1; regWrIdx = 3'(wrIdx); regWrData = wrData; end
      @(negedge clk);
      regWrEn = 0;
      if (k == 2) begin byteValid = 0; @(negedge clk); end  // gap
    end
    byteValid = 0;
    check({tag, " no strobe before latency (R8)"}, decValid, 1'b0);
    @(negedge clk);
    check({tag, " strobe (R8)"}, decValid, 1'b1);
    check(tag, decAccept, expA);
    byteValid = 1; byteData = 8'hFF;          // extra bytes ignored
    @(negedge clk);
    byteData = 8'h00;
    @(negedge clk);
    byteValid = 0;
    @(negedge clk);
    check({tag, " held, extra bytes ignored (R8)"}, decAccept, expA);
    check({tag, " single strobe (R8)"}, decValid, 1'b0);
  endtask

  localparam logic [47:0] ADDR_A = 48'h6655_4433_2211;
  localparam logic [47:0] ADDR_B = 48'h0F0E_DDCC_BBAA;
  localparam logic [47:0] BCAST  = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MCAST  = 48'h0000_5E00_0001;  // byte0 = 01: group
  localparam logic [47:0] MCAST2 = 48'h3355_AA77_C103;  // byte0 = 03: group
  localparam logic [47:0] UCAST  = 48'h0000_0000_1234;  // byte0 = 34: individual

  function automatic int hashOfAddr(input logic [47:0] a);
    logic [7:0] b [6];
    for (int k = 0; k < 6; k++) b[k] = a[8*k +: 8];
    return hashOf(b);
  endfunction

  task automatic setHashBit(input int h);
    wrReg(4, (h < 32) ? (32'd1 << h) : 32'd0);
    wrReg(5, (h >= 32) ? (32'd1 << (h - 32)) : 32'd0);
  endtask

  initial begin
    int h;
    repeat (3) @(negedge clk);
    check("R1 reset decValid", decValid, 1'b0);
    check("R1 reset decAccept", decAccept, 1'b0);
    rstN = 1;
    @(negedge clk);
    sendFrame(ADDR_A, 64, "R1 all switches off after reset", 1'b0, -1, 0, 0);

    wrReg(0, 32'h4433_2211); wrReg(1, 32'h0000_6655);
    wrReg(2, 32'hDDCC_BBAA); wrReg(3, 32'h0000_0F0E);

    wrReg(6, 32'h0);
    sendFrame(ADDR_A, 64, "R2 station A disabled", 1'b0, -1, 0, 0);
    wrReg(6, 32'h1);
    sendFrame(ADDR_A, 64, "R2 station A match", 1'b1, -1, 0, 0);
    sendFrame(ADDR_A ^ 48'h0100_0000_0000, 64, "R2 station A byte5 differs", 1'b0, -1, 0, 0);
    sendFrame(ADDR_B, 64, "R3 station B while only A enabled", 1'b0, -1, 0, 0);
    wrReg(6, 32'h2);
    sendFrame(ADDR_B, 64, "R3 station B match", 1'b1, -1, 0, 0);

    wrReg(6, 32'h0);
    sendFrame(BCAST, 64, "R4 broadcast disabled", 1'b0, -1, 0, 0);
    wrReg(6, 32'h8);
    sendFrame(BCAST, 64, "R4 broadcast enabled", 1'b1, -1, 0, 0);

    wrReg(6, 32'h0);
    h = hashOfAddr(MCAST);
    setHashBit(h);
    sendFrame(MCAST, 64, "R5 group hash hit", 1'b1, -1, 0, 0);
    wrReg(4, (h < 32) ? ~(32'd1 << h) : 32'hFFFF_FFFF);
    wrReg(5, (h >= 32) ? ~(32'd1 << (h - 32)) : 32'hFFFF_FFFF);
    sendFrame(MCAST, 64, "R5 group hash miss", 1'b0, -1, 0, 0);
    setHashBit(hashOfAddr(MCAST2));
    sendFrame(MCAST2, 64, "R5 second group hash hit", 1'b1, -1, 0, 0);

    setHashBit(hashOfAddr(UCAST));
    sendFrame(UCAST, 64, "R6 individual hash blocked", 1'b0, -1, 0, 0);
    wrReg(6, 32'h4);
    sendFrame(UCAST, 64, "R6 individual hash allowed", 1'b1, -1, 0, 0);

    wrReg(6, 32'h1);
    sendFrame(ADDR_A, 11, "R7 short frame rejected", 1'b0, -1, 0, 0);
    sendFrame(ADDR_A, 12, "R7 minimum length accepted", 1'b1, -1, 0, 0);

    sendFrame(ADDR_A, 64, "R9 write with start uses old ctrl", 1'b1, 0, 6, 32'h0);
    sendFrame(ADDR_A, 64, "R9 next frame uses new ctrl", 1'b0, -1, 0, 0);
    sendFrame(ADDR_A, 64, "R9 mid-frame write ignored", 1'b0, 3, 6, 32'h1);
    sendFrame(ADDR_A, 64, "R9 mid-frame write applies next", 1'b1, -1, 0, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule